// File: doc/BRIEF.md
# Conversion-Averaging Serial Output Unit

This unit sits behind a converter core that produces one 24-bit two's complement result per conversion, each marked by a one-cycle valid strobe. It gathers a programmable number N of consecutive results, divides their sum by N with rounding to nearest, and holds the mean at the scale of a single conversion. A host reads the held mean over a serial link clocked by its own SCK and framed by an active-low chip select. The word comes out as 24 result bits, MSB first, followed without a break by a 16-bit field carrying N-1.

The averaging length is given as N-1 on a 16-bit input, so N runs from 1 to 65536. It is captured when the first conversion of a block arrives. The host lines are brought into the system clock domain through two-stage synchronizers. The output bit changes on each rising SCK edge, so the host samples it on the falling edge. Once a read has clocked out the full 24-bit result, the stored result is set to zero. A busy output shows that a block is being gathered or divided.

Conversions must be spaced at least 44 system clocks apart, which covers the serial divider. Each SCK phase must last at least four system clocks.

Top module: `avg_sout_unit`

## Requirements
- R1: After N conversions of equal value, the 24-bit result field read out equals that value.
- R2: The result is the sum of the N conversions divided by N, rounded to nearest, with an exact half rounded away from zero (1,2 gives 2; -1,-2 gives -2; 1..4 gives 3; -4..-1 gives -3).
- R3: A frame holds 40 bits. Bits 1 to 24 carry the result in two's complement, MSB first. Bits 25 to 40 carry N-1, MSB first.
- R4: The serial output changes only in response to a rising SCK edge. A bit presented after a rising edge stays stable until the next rising edge.
- R5: The 24th rising SCK edge of a frame clears the stored result to zero. The stored count field is kept. A later frame returns a result of 0.
- R6: A frame that ends with fewer than 24 rising SCK edges leaves the stored result unchanged.
- R7: The stored result changes only when the N-th conversion of a block has been divided. A read taken during an unfinished block returns the previous result and count.
- R8: busy is high from the first conversion of a block until its mean is stored, and low otherwise.
- R9: Blocks of full-scale conversions (-8388608 or 8388607) average without overflow to the same full-scale value.
- R10: The serial output is 0 while chip select is inactive and before the first rising SCK edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new conversion result |
| smp_data | input | 24 | Conversion result, two's complement |
| avg_nm1 | input | 16 | Averaging length minus one, captured at block start |
| sck | input | 1 | Host serial clock |
| cs_n | input | 1 | Host chip select, active low |
| sdo | output | 1 | Serial data to host |
| busy | output | 1 | Block being gathered or divided |

## Verification
The hardest case to reach from the ports is a read that lands inside a block that is only partly gathered, because the stored result must survive while the accumulator already holds new data. The stimulus first completes a one-conversion block, then switches to a two-conversion block, feeds a single conversion and reads a whole frame before the second conversion arrives. Rounding ties in both signs and full-scale blocks of 300 conversions also need long, exact input runs. These come from arithmetic sequences in the vector table and from directed runs.

// File: rtl/avg_sout_pkg.sv
// Shared definitions for the conversion-averaging serial output unit.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package avg_sout_pkg;

    localparam int SAMP_W_DEF = 24;   // conversion result width
    localparam int CNT_W_DEF  = 16;   // averaging count field width

    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/avg_sout_accum.sv
// Block accumulator: sums consecutive conversion results until the
// captured count (N-1) is reached, then hands the sum and N-1 onward
// with a one-cycle pulse. Assumes ACC_W >= SAMP_W + CNT_W so that
// 2^CNT_W full-scale results cannot overflow.
module avg_sout_accum #(
    parameter int SAMP_W = avg_sout_pkg::SAMP_W_DEF,
    parameter int CNT_W  = avg_sout_pkg::CNT_W_DEF,
    parameter int ACC_W  = SAMP_W + CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic [SAMP_W-1:0]        smp_data,
    input  logic [CNT_W-1:0]         avg_nm1,
    output logic                     blk_vld,
    output logic signed [ACC_W-1:0]  blk_sum,
    output logic [CNT_W-1:0]         blk_nm1,
    output logic                     active
);

    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        lat_q;
    logic                    act_q;

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] sum_nxt;
    logic [CNT_W-1:0]        cur_nm1;
    logic [CNT_W-1:0]        cur_cnt;
    logic                    last;

    // Sign-extend the result and form the running sum and end-of-block test.
    always_comb begin
        ext     = {{(ACC_W-SAMP_W){smp_data[SAMP_W-1]}}, smp_data};
        cur_nm1 = act_q ? lat_q : avg_nm1;
        cur_cnt = act_q ? cnt_q : '0;
        sum_nxt = (act_q ? acc_q : '0) + ext;
        last    = (cur_cnt == cur_nm1);
    end

    // Accumulate, count and emit the block sum at the N-th result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            lat_q   <= '0;
            act_q   <= 1'b0;
            blk_vld <= 1'b0;
            blk_sum <= '0;
            blk_nm1 <= '0;
        end else begin
            blk_vld <= 1'b0;
            if (smp_vld) begin
                if (last) begin
                    blk_vld <= 1'b1;
                    blk_sum <= sum_nxt;
                    blk_nm1 <= cur_nm1;
                    acc_q   <= '0;
                    cnt_q   <= '0;
                    act_q   <= 1'b0;
                end else begin
                    acc_q   <= sum_nxt;
                    cnt_q   <= cur_cnt + 1'b1;
                    lat_q   <= cur_nm1;
                    act_q   <= 1'b1;
                end
            end
        end
    end

    assign active = act_q;

    // R1
    blk_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> ((cnt_q != '0) && (cnt_q <= lat_q)));

    // R8
    blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |-> !act_q);

endmodule

// File: rtl/avg_sout_div.sv
// Rounding divider: computes round(sum / N), with ties away from zero,
// by restoring long division of |sum| + floor(N/2) over ACC_W steps.
// Assumes a new start never arrives while a division is running, and
// that the rounded mean fits SAMP_W bits (true for a mean of SAMP_W values).
module avg_sout_div #(
    parameter int SAMP_W = avg_sout_pkg::SAMP_W_DEF,
    parameter int CNT_W  = avg_sout_pkg::CNT_W_DEF,
    parameter int ACC_W  = SAMP_W + CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [ACC_W-1:0]  sum,
    input  logic [CNT_W-1:0]         nm1,
    output logic                     done,
    output logic [SAMP_W-1:0]        mean,
    output logic [CNT_W-1:0]         done_nm1,
    output logic                     running
);
    import avg_sout_pkg::*;

    localparam int STEP_W = $clog2(ACC_W);
    localparam int REM_W  = CNT_W + 1;

    div_state_e           st_q;
    logic [ACC_W-1:0]     dvd_q;
    logic [REM_W-1:0]     rem_q;
    logic [REM_W-1:0]     dvs_q;
    logic [SAMP_W-1:0]    quo_q;
    logic [STEP_W-1:0]    step_q;
    logic                 neg_q;

    logic [ACC_W-1:0]     mag;
    logic [REM_W-1:0]     dvs_w;
    logic [REM_W:0]       rem_sh;
    logic [REM_W:0]       diff;
    logic                 qbit;
    logic [SAMP_W-1:0]    quo_nxt;

    // Magnitude, divisor and one restoring step.
    always_comb begin
        mag     = sum[ACC_W-1] ? (~sum + 1'b1) : sum;
        dvs_w   = {1'b0, nm1} + 1'b1;
        rem_sh  = {rem_q, dvd_q[ACC_W-1]};
        diff    = rem_sh - {1'b0, dvs_q};
        qbit    = ~diff[REM_W];
        quo_nxt = {quo_q[SAMP_W-2:0], qbit};
    end

    // Division sequencer and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= DIV_IDLE;
            dvd_q    <= '0;
            rem_q    <= '0;
            dvs_q    <= '0;
            quo_q    <= '0;
            step_q   <= '0;
            neg_q    <= 1'b0;
            done     <= 1'b0;
            mean     <= '0;
            done_nm1 <= '0;
        end else begin
            done <= 1'b0;
            if (st_q == DIV_IDLE) begin
                if (start) begin
                    st_q     <= DIV_RUN;
                    dvd_q    <= mag + ACC_W'(dvs_w >> 1);
                    dvs_q    <= dvs_w;
                    rem_q    <= '0;
                    quo_q    <= '0;
                    step_q   <= '0;
                    neg_q    <= sum[ACC_W-1];
                    done_nm1 <= nm1;
                end
            end else begin
                rem_q  <= qbit ? diff[REM_W-1:0] : rem_sh[REM_W-1:0];
                quo_q  <= quo_nxt;
                dvd_q  <= {dvd_q[ACC_W-2:0], 1'b0};
                step_q <= step_q + 1'b1;
                if (step_q == STEP_W'(ACC_W-1)) begin
                    st_q <= DIV_IDLE;
                    done <= 1'b1;
                    mean <= neg_q ? (~quo_nxt + 1'b1) : quo_nxt;
                end
            end
        end
    end

    assign running = (st_q == DIV_RUN);

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DIV_RUN) |-> (rem_q < dvs_q));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !neg_q) |-> !mean[SAMP_W-1]);

endmodule

// File: rtl/avg_sout_ser.sv
// Serial output stage: synchronizes host SCK and chip select, holds the
// stored mean and count, loads a frame at chip-select assertion and
// shifts one bit per rising SCK edge. Clears the stored mean after the
// SAMP_W-th rising edge. Assumes each SCK phase spans >= 4 clk cycles.
module avg_sout_ser #(
    parameter int SAMP_W = avg_sout_pkg::SAMP_W_DEF,
    parameter int CNT_W  = avg_sout_pkg::CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               ld,
    input  logic [SAMP_W-1:0]  ld_mean,
    input  logic [CNT_W-1:0]   ld_nm1,
    output logic               sdo
);

    localparam int FRAME_W = SAMP_W + CNT_W;
    localparam int ECW     = $clog2(FRAME_W + 1);

    logic [2:0]          sck_s;
    logic [2:0]          cs_s;
    logic [SAMP_W-1:0]   res_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [FRAME_W-1:0]  shreg;
    logic [ECW-1:0]      edge_q;
    logic                sdo_q;

    logic                sck_rise;
    logic                cs_act;
    logic                cs_fall;
    logic                clr;

    // Two-stage synchronizers plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= '0;
            cs_s  <= '1;
        end else begin
            sck_s <= {sck_s[1:0], sck};
            cs_s  <= {cs_s[1:0], cs_n};
        end
    end

    // Edge events and the clear condition on the SAMP_W-th rising edge.
    always_comb begin
        sck_rise = sck_s[1] & ~sck_s[2];
        cs_act   = ~cs_s[1];
        cs_fall  = ~cs_s[1] & cs_s[2];
        clr      = cs_act && !cs_fall && sck_rise && (edge_q == ECW'(SAMP_W-1));
    end

    // Stored mean and count; a fresh load takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            cnt_q <= '0;
        end else if (ld) begin
            res_q <= ld_mean;
            cnt_q <= ld_nm1;
        end else if (clr) begin
            res_q <= '0;
        end
    end

    // Frame load at select, one bit out per rising SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            edge_q <= '0;
            sdo_q  <= 1'b0;
        end else if (!cs_act) begin
            edge_q <= '0;
            sdo_q  <= 1'b0;
        end else if (cs_fall) begin
            shreg  <= {res_q, cnt_q};
            edge_q <= '0;
            sdo_q  <= 1'b0;
        end else if (sck_rise) begin
            sdo_q  <= shreg[FRAME_W-1];
            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
            if (edge_q != ECW'(FRAME_W))
                edge_q <= edge_q + 1'b1;
        end
    end

    assign sdo = sdo_q;

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_rise) |=> $stable(sdo_q));

    // R5
    clr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld) |=> (res_q == '0));

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr) |=> $stable(res_q));

    // R10
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act || cs_fall) |=> !sdo_q);

endmodule

// File: rtl/avg_sout_unit.sv
// Top of the conversion-averaging serial output unit: accumulator,
// rounding divider and serial output stage. Assumes conversions are at
// least ACC_W + 4 clk cycles apart and avg_nm1 is steady at block start.
module avg_sout_unit #(
    parameter int SAMP_W = avg_sout_pkg::SAMP_W_DEF,
    parameter int CNT_W  = avg_sout_pkg::CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld,
    input  logic [SAMP_W-1:0]  smp_data,
    input  logic [CNT_W-1:0]   avg_nm1,
    input  logic               sck,
    input  logic               cs_n,
    output logic               sdo,
    output logic               busy
);

    localparam int ACC_W = SAMP_W + CNT_W;

    logic                     blk_vld;
    logic signed [ACC_W-1:0]  blk_sum;
    logic [CNT_W-1:0]         blk_nm1;
    logic                     acc_active;
    logic                     div_done;
    logic [SAMP_W-1:0]        div_mean;
    logic [CNT_W-1:0]         div_nm1;
    logic                     div_running;

    avg_sout_accum #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .avg_nm1  (avg_nm1),
        .blk_vld  (blk_vld),
        .blk_sum  (blk_sum),
        .blk_nm1  (blk_nm1),
        .active   (acc_active)
    );

    avg_sout_div #(.SAMP_W(SAMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (blk_vld),
        .sum      (blk_sum),
        .nm1      (blk_nm1),
        .done     (div_done),
        .mean     (div_mean),
        .done_nm1 (div_nm1),
        .running  (div_running)
    );

    avg_sout_ser #(.SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .ld      (div_done),
        .ld_mean (div_mean),
        .ld_nm1  (div_nm1),
        .sdo     (sdo)
    );

    // Busy spans gathering, hand-over and division.
    assign busy = acc_active | blk_vld | div_running;

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> !div_running);

endmodule

// File: tb/avg_sout_unit_bench.sv
module avg_sout_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_data = '0;
    logic [15:0] avg_nm1 = '0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdo;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    avg_sout_unit u_avg_sout_unit (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .avg_nm1(avg_nm1), .sck(sck), .cs_n(cs_n), .sdo(sdo), .busy(busy)
    );

    localparam int VN = 9;
    localparam int V_NM1  [VN] = '{0, 1, 1, 3, 2, 3, 3, 4, 15};
    localparam int V_BASE [VN] = '{100, 1, -1, -3, 10, 1, -4, -1000, 8388592};
    localparam int V_STEP [VN] = '{0, 1, -1, 2, 1, 1, 1, 3, 1};
    localparam int V_EXP  [VN] = '{100, 2, -2, 0, 11, 3, -3, -994, 8388600};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int v);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = 24'(v);
        @(negedge clk);
        smp_vld  = 1'b0;
        repeat (50) @(negedge clk);
    endtask

    // Reads nb bits, host sampling after each falling SCK edge.
    task automatic spi_read(input int nb, output logic [39:0] word);
        bit stable = 1'b1;
        bit idle_ok;
        logic b1;
        word = '0;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        idle_ok = (sdo == 1'b0);
        for (int k = 0; k < nb; k++) begin
            sck = 1'b1;
            repeat (6) @(negedge clk);
            b1 = sdo;
            sck = 1'b0;
            repeat (3) @(negedge clk);
            if (sdo !== b1) stable = 1'b0;
            word = {word[38:0], sdo};
            repeat (3) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(stable, "R4 sdo stable between rising edges", int'(stable), 1);
        chk(idle_ok, "R10 sdo low before first edge", int'(!idle_ok), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [39:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state
        chk(busy == 1'b0, "R8 busy after reset", int'(busy), 0);
        chk(sdo == 1'b0, "R10 sdo idle after reset", int'(sdo), 0);
        spi_read(40, w);
        chk(w == 40'd0, "R3 reset frame", int'(w[39:16]), 0);

        // Vector table
        for (int i = 0; i < VN; i++) begin
            avg_nm1 = 16'(V_NM1[i]);
            for (int j = 0; j <= V_NM1[i]; j++) begin
                put(V_BASE[i] + j * V_STEP[i]);
                if (j == 0 && V_NM1[i] > 0)
                    chk(busy == 1'b1, "R8 busy mid-block", int'(busy), 1);
            end
            chk(busy == 1'b0, "R8 busy after block", int'(busy), 0);
            spi_read(40, w);
            chk(int'($signed(w[39:16])) == V_EXP[i], "R1 R2 mean",
                int'($signed(w[39:16])), V_EXP[i]);
            chk(int'(w[15:0]) == V_NM1[i], "R3 count field",
                int'(w[15:0]), V_NM1[i]);
        end

        // R5: previous full read cleared the result, count kept
        spi_read(40, w);
        chk(w[39:16] == 24'd0, "R5 result cleared", int'($signed(w[39:16])), 0);
        chk(int'(w[15:0]) == 15, "R5 count kept", int'(w[15:0]), 15);

        // R6: partial read keeps result; MSB-first order
        avg_nm1 = 16'd0;
        put(1234);
        spi_read(16, w);
        chk(w[15:0] == 16'h0004, "R3 MSB first", int'(w[15:0]), 4);
        spi_read(40, w);
        chk(int'($signed(w[39:16])) == 1234, "R6 partial read kept result",
            int'($signed(w[39:16])), 1234);

        // R7: read during unfinished block returns previous result
        put(555);
        avg_nm1 = 16'd1;
        put(7);
        chk(busy == 1'b1, "R8 busy during partial block", int'(busy), 1);
        spi_read(40, w);
        chk(int'($signed(w[39:16])) == 555, "R7 previous result held",
            int'($signed(w[39:16])), 555);
        chk(int'(w[15:0]) == 0, "R7 previous count held", int'(w[15:0]), 0);
        put(9);
        spi_read(40, w);
        chk(int'($signed(w[39:16])) == 8, "R7 new result", int'($signed(w[39:16])), 8);
        chk(int'(w[15:0]) == 1, "R7 new count", int'(w[15:0]), 1);

        // R9: full-scale blocks
        avg_nm1 = 16'd299;
        for (int j = 0; j < 300; j++) put(-8388608);
        spi_read(40, w);
        chk(int'($signed(w[39:16])) == -8388608, "R9 negative full scale",
            int'($signed(w[39:16])), -8388608);
        chk(int'(w[15:0]) == 299, "R9 count", int'(w[15:0]), 299);
        for (int j = 0; j < 300; j++) put(8388607);
        spi_read(40, w);
        chk(int'($signed(w[39:16])) == 8388607, "R9 positive full scale",
            int'($signed(w[39:16])), 8388607);

        // R10: idle output with select inactive
        repeat (4) @(negedge clk);
        chk(sdo == 1'b0, "R10 sdo idle", int'(sdo), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule